// File: doc/BRIEF.md
# Three-Lane Interleaved Frame Serializer

This block turns a 120-bit parallel frame into a single serial bitstream, one bit per cycle of the bit clock `clk`. The frame is held in a 120-bit capture register. At each frame boundary it is split into three 40-bit words. Each word goes into its own shift lane, and each lane advances only once every third bit time. A three-way selector walks across the lanes each bit time, so the three slow lanes are interleaved into the full-rate output.

A two-stage divider, first by 3 and then by 40, marks the frame boundary once per 120 bit times. That boundary drives the capture register and the lane reload. The divider state is kept in three copies and read through a bitwise majority vote. Every copy is rewritten from the voted value on each cycle, so a single corrupted copy is outvoted and then corrected. A disagreement between the copies sets a sticky flag. A per-copy fault-injection input lets one copy be corrupted on purpose, so that the redundancy can be exercised.

Top module: `tri_lane_serializer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ser_out`, `frame_tick` and `upset_seen` are all 0. All lanes and the capture register clear to zero.
- R2: `frame_tick` is high for exactly one cycle in every 120. Counting the first cycle after reset release as cycle 0, it is first high in cycle 119.
- R3: The capture register takes `frame_in` only at the clock edge that ends a `frame_tick` cycle. `frame_in` has no effect in any other cycle.
- R4: A frame captured at tick n is sent in the 120 cycles that follow tick n+1. Bit 119 goes first, then bits in descending order, with no gap between frames. The first two frames after reset are all zero.
- R5: Lane k (k = 0, 1, 2) carries the frame bits whose index mod 3 equals k. In each group of three cycles the output takes lane 2, then lane 1, then lane 0. The lanes step once per three cycles, and the reload replaces the step at the frame boundary.
- R6: Asserting `flip_copy[i]` in cycle c corrupts copy i only, from cycle c+1. Neither `ser_out` nor `frame_tick` changes. `upset_seen` becomes 1 in cycle c+2 and stays 1 until reset.
- R7: After a single-copy upset, all three copies agree again one cycle later. A later upset on a different copy is therefore also masked.
- R8: An upset injected in the cycle that carries `frame_tick` leaves the tick schedule, the capture and the lane reload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_in | input | 120 | Parallel frame, sampled at the end of a `frame_tick` cycle |
| flip_copy | input | 3 | Fault injection: bit i corrupts divider copy i at the next edge |
| ser_out | output | 1 | Serial data, frame bit 119 first |
| frame_tick | output | 1 | One-cycle frame boundary pulse (divider terminal count) |
| upset_seen | output | 1 | Sticky flag: the divider copies disagreed |

## Verification
Two functions can fall in the same cycle. One is the frame boundary, where the last bit leaves lane 0 and all lanes reload while `frame_in` is captured. The other is the repair of a divider copy after a fault. This is provoked by pulsing `flip_copy` exactly in a `frame_tick` cycle, and in another run in the cycle just before one. A second copy is then hit a few cycles later. The collision is judged at the ports: every bit of the next two frames must still match the expected descending order, the tick must keep its 120-cycle spacing, and `upset_seen` must rise exactly two cycles after the first injection.

// File: rtl/tls_pkg.sv
package tls_pkg;
  parameter int LANES  = 3;
  parameter int WORD_W = 40;
  parameter int COPIES = 3;
  localparam int FRAME_W = LANES * WORD_W;
  localparam int PH_W    = $clog2(LANES);
  localparam int WD_W    = $clog2(WORD_W);

  typedef struct packed {
    logic [PH_W-1:0] ph;
    logic [WD_W-1:0] wd;
  } div_state_t;

  // Next state of the divide-by-LANES then divide-by-WORD_W chain.
  function automatic div_state_t div_advance(div_state_t s);
    div_state_t r;
    r = s;
    if (s.ph >= PH_W'(LANES - 1)) begin
      r.ph = '0;
      r.wd = (s.wd >= WD_W'(WORD_W - 1)) ? '0 : s.wd + WD_W'(1);
    end else begin
      r.ph = s.ph + PH_W'(1);
    end
    return r;
  endfunction

  // Bitwise two-of-three majority.
  function automatic div_state_t vote3(div_state_t a, div_state_t b, div_state_t c);
    return div_state_t'((a & b) | (a & c) | (b & c));
  endfunction

  // Word for lane k: frame bits whose index mod LANES is k, highest first.
  function automatic logic [WORD_W-1:0] lane_slice(logic [FRAME_W-1:0] f, int k);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < WORD_W; j++) w[j] = f[LANES * j + k];
    return w;
  endfunction
endpackage

// File: rtl/tls_frame_divider.sv
module tls_frame_divider
  import tls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COPIES-1:0] flip_copy,
  output logic [PH_W-1:0]   phase,
  output logic              lane_step,
  output logic              frame_tick,
  output logic              copy_mismatch,
  output logic              upset_seen
);
  localparam div_state_t FLIP_MASK = '{ph: PH_W'(1), wd: WD_W'(1)};

  div_state_t        copy_q [COPIES];
  div_state_t        voted;
  div_state_t        advanced;
  logic [COPIES-1:0] differs;

  assign voted    = vote3(copy_q[0], copy_q[1], copy_q[2]);
  assign advanced = div_advance(voted);

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) copy_q[i] <= '0;
      else        copy_q[i] <= flip_copy[i] ? div_state_t'(advanced ^ FLIP_MASK) : advanced;
    end
    assign differs[i] = (copy_q[i] != voted);
  end

  assign copy_mismatch = |differs;
  assign phase         = voted.ph;
  assign lane_step     = (voted.ph == PH_W'(LANES - 1));
  assign frame_tick    = lane_step && (voted.wd == WD_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             upset_seen <= 1'b0;
    else if (copy_mismatch) upset_seen <= 1'b1;
  end
endmodule

// File: rtl/tls_lane_bank.sv
module tls_lane_bank
  import tls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic               lane_step,
  input  logic [PH_W-1:0]    phase,
  input  logic [FRAME_W-1:0] frame_in,
  output logic [FRAME_W-1:0] held_frame,
  output logic               ser_out
);
  logic [FRAME_W-1:0] hold_q;
  logic [LANES-1:0]   lane_msb;
  logic [PH_W-1:0]    sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (frame_tick) hold_q <= frame_in;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WORD_W-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sh_q <= '0;
      else if (frame_tick) sh_q <= lane_slice(hold_q, k);
      else if (lane_step)  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
    assign lane_msb[k] = sh_q[WORD_W-1];
  end

  assign sel        = PH_W'(LANES - 1) - phase;
  assign ser_out    = (phase < PH_W'(LANES)) ? lane_msb[sel] : 1'b0;
  assign held_frame = hold_q;
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer
  import tls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [COPIES-1:0]  flip_copy,
  output logic               ser_out,
  output logic               frame_tick,
  output logic               upset_seen
);
  logic [PH_W-1:0]    phase;
  logic               lane_step;
  logic               copy_mismatch;
  logic [FRAME_W-1:0] held_frame;

  tls_frame_divider u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .flip_copy    (flip_copy),
    .phase        (phase),
    .lane_step    (lane_step),
    .frame_tick   (frame_tick),
    .copy_mismatch(copy_mismatch),
    .upset_seen   (upset_seen)
  );

  tls_lane_bank u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .lane_step (lane_step),
    .phase     (phase),
    .frame_in  (frame_in),
    .held_frame(held_frame),
    .ser_out   (ser_out)
  );
endmodule

// File: rtl/tls_checker.sv
module tls_checker
  import tls_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [FRAME_W-1:0] frame_in,
  input logic [COPIES-1:0]  flip_copy,
  input logic               frame_tick,
  input logic               lane_step,
  input logic               copy_mismatch,
  input logic               upset_seen,
  input logic [FRAME_W-1:0] held_frame
);
  localparam int GW = $clog2(FRAME_W + 1);
  localparam int SW = $clog2(LANES + 1);

  logic [GW-1:0] gap;
  logic [SW-1:0] step_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      step_gap <= '0;
    end else begin
      gap      <= frame_tick ? '0 : gap + GW'(1);
      step_gap <= lane_step ? '0 : step_gap + SW'(1);
    end
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> gap == GW'(FRAME_W - 1));
  assert_tick_not_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GW'(FRAME_W - 1));
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> held_frame == $past(frame_in));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(held_frame));
  assert_step_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lane_step |-> step_gap == SW'(LANES - 1));
  assert_tick_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> lane_step);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_mismatch |=> upset_seen);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upset_seen |=> upset_seen);
  assert_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_mismatch && flip_copy == '0) |=> !copy_mismatch);
endmodule

bind tri_lane_serializer tls_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_in     (frame_in),
  .flip_copy    (flip_copy),
  .frame_tick   (frame_tick),
  .lane_step    (lane_step),
  .copy_mismatch(copy_mismatch),
  .upset_seen   (upset_seen),
  .held_frame   (held_frame)
);

// File: tb/tb_tri_lane_serializer.sv
module tb_tri_lane_serializer;
  localparam int FW = 120;
  localparam int FRAMES = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] frame_in = '0;
  logic [2:0]    flip_copy = '0;
  logic          ser_out, frame_tick, upset_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tri_lane_serializer dut (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .flip_copy(flip_copy),
    .ser_out(ser_out), .frame_tick(frame_tick), .upset_seen(upset_seen)
  );

  task automatic check(bit ok, string req, string what, logic [FW-1:0] got, logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reset, then run FRAMES frames; fa/fb/fc are offered only in tick cycles.
  task automatic run_stream(input logic [FW-1:0] fa, fb, fc,
                            input int fl_a, input int ia, input int fl_b, input int ib,
                            input string tag);
    logic [FW-1:0] got_d, got_t, exp_d;
    int flag_bad, first_flag;
    @(negedge clk);
    rst_n = 1'b0; frame_in = '0; flip_copy = '0;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b0 && frame_tick === 1'b0 && upset_seen === 1'b0, "R1",
          {tag, " outputs in reset"}, {ser_out, frame_tick, upset_seen}, '0);
    rst_n = 1'b1;
    check(ser_out === 1'b0 && frame_tick === 1'b0 && upset_seen === 1'b0, "R1",
          {tag, " outputs after release"}, {ser_out, frame_tick, upset_seen}, '0);
    for (int n = 0; n < FRAMES; n++) begin
      got_d = '0; got_t = '0; flag_bad = 0; first_flag = 0;
      for (int p = 0; p < FW; p++) begin
        int c;
        bit exp_flag;
        c = n * FW + p;
        got_d[FW-1-p] = ser_out;
        got_t[FW-1-p] = frame_tick;
        exp_flag = (fl_a >= 0) && (c >= fl_a + 2);
        if (upset_seen !== exp_flag && flag_bad == 0) first_flag = c;
        if (upset_seen !== exp_flag) flag_bad++;
        // drive inputs for this cycle
        if (c == 119)      frame_in = fa;
        else if (c == 239) frame_in = fb;
        else if (c == 359) frame_in = fc;
        else frame_in = {4{30'h1AB3C5D1}} ^ {FW{c[0]}};
        flip_copy = '0;
        if (c == fl_a) flip_copy[ia] = 1'b1;
        if (c == fl_b) flip_copy[ib] = 1'b1;
        @(negedge clk);
      end
      case (n)
        2: exp_d = fa;
        3: exp_d = fb;
        4: exp_d = fc;
        default: exp_d = '0;
      endcase
      check(got_d === exp_d, "R3 R4 R5", $sformatf("%s frame %0d data", tag, n), got_d, exp_d);
      check(got_t === {{(FW-1){1'b0}}, 1'b1}, "R2",
            $sformatf("%s frame %0d tick position", tag, n), got_t, {{(FW-1){1'b0}}, 1'b1});
      if (fl_a >= 0)
        check(flag_bad == 0, "R6 R7", $sformatf("%s frame %0d upset flag (first bad cycle)", tag, n),
              FW'(first_flag), FW'(fl_a + 2));
    end
    frame_in = '0; flip_copy = '0;
  endtask

  task automatic t_patterns();
    run_stream({60{2'b10}}, {40{3'b011}}, {4{30'h2D5A0F3C}}, -1, 0, -1, 0, "patterns R4 R5");
  endtask

  task automatic t_edge_bits();
    run_stream({{(FW-1){1'b0}}, 1'b1}, {1'b1, {(FW-1){1'b0}}}, FW'(1) << 61, -1, 0, -1, 0,
               "edge bits R4 R5");
  endtask

  task automatic t_upset_mid();
    run_stream({FW{1'b1}}, {30{4'h9}}, {60{2'b01}}, 250, 1, 260, 0, "mid-frame upset R6 R7");
  endtask

  task automatic t_upset_tick();
    run_stream({30{4'hC}}, {40{3'b101}}, {3{40'hF0F0_1234_5A}}, 359, 2, 365, 1, "tick upset R8");
  endtask

  task automatic t_upset_before_tick();
    run_stream({24{5'b10011}}, {FW{1'b0}} | 120'h1, {8{15'h3A5C}}, 238, 0, 241, 2,
               "pre-tick upset R8");
  endtask

  initial begin
    fork
      begin
        t_patterns();
        t_edge_bits();
        t_upset_mid();
        t_upset_tick();
        t_upset_before_tick();
        // R1 again: reset clears a set flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(upset_seen === 1'b0, "R1", "flag cleared by reset", FW'(upset_seen), '0);
        rst_n = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule